// File: doc/BRIEF.md
# TFT Panel Control-Register Writer over SPI

This block is a write-only SPI master that programs the control registers of a small TFT panel. Each register write goes out as two back-to-back 24-bit transfers, and chip select is framed separately around each one. The first transfer selects the register: a fixed 0x74 prefix byte, a zero byte, then the register number. The second transfer carries the value: a fixed 0x76 prefix byte, then the 16-bit value, high byte first. The bus runs in SPI mode 3. SCK idles high, MOSI changes while SCK is low, and the panel samples on each rising SCK edge. Bits go out MSB first.

A small built-in sequencer turns three start strobes into jobs. The power-up job wakes the panel by writing 0x0000 to register 0x11. It then programs register 0x01 with the fixed default 0x00EF, merged with the caller's mode word restricted to bits 8, 9, 11 and 13. The shutdown job writes 0x0001 to register 0x11. The user job writes any register with any value from the request port. The block raises busy while a job runs and pulses done once when the job finishes.

The SCK rate is set by the parameter `SCK_HALF`, the number of system clocks in each half period of SCK. It must be chosen so that SCK stays at or below 20 MHz. The default of 2 gives 12.5 MHz from a 50 MHz clock.

Top module: `panel_spi_ctrl`

## Requirements
- R1: After reset, and whenever no job is running, cs_n and sck are 1, mosi is 0, and busy and done are 0.
- R2: SPI mode 3. sck is 1 in the cycle where cs_n falls and in the cycle where it rises. mosi holds steady while sck is high inside a frame, so every rising sck edge samples a settled bit.
- R3: Every chip-select frame holds exactly 24 rising sck edges, sent MSB first. The index frame is bits 23..16 = 0x74, bits 15..8 = 0x00 and bits 7..0 = the register number.
- R4: The data frame that follows each index frame is bits 23..16 = 0x76, bits 15..8 = value high byte and bits 7..0 = value low byte.
- R5: cs_n returns high between any two frames, including between the index frame and the data frame of one write, for at least 2*SCK_HALF clock cycles.
- R6: An init_go job sends two writes in this order: register 0x11 with 0x0000, then register 0x01 with (mode_word & 0x2B00) | 0x00EF. Bit 8 of the mode word selects left-to-right scan, bit 9 top-to-bottom, bit 11 BGR order and bit 13 non-reversed display.
- R7: A shut_go job sends one write of 0x0001 to register 0x11.
- R8: A wr_req job sends one write of wr_data to register wr_reg.
- R9: busy is 1 from the clock edge that accepts a strobe until the final frame has ended. done is then 1 for exactly one cycle, in the first cycle where busy is 0.
- R10: Strobes that arrive while busy is 1 are ignored. No extra frame follows the running job.
- R11: Strobes that arrive in the same idle cycle start only one job, with priority init_go over shut_go over wr_req.
- R12: Each low phase and each high phase of sck inside a frame lasts SCK_HALF clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_go | input | 1 | Strobe: run the power-up job |
| shut_go | input | 1 | Strobe: run the shutdown job |
| mode_word | input | 16 | Scan and colour option bits, sampled with init_go |
| wr_req | input | 1 | Strobe: write one register from wr_reg and wr_data |
| wr_reg | input | 8 | Register number for a user write |
| wr_data | input | 16 | Value for a user write |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the panel |
| cs_n | output | 1 | Active-low chip select, one low window per frame |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at the end of a job |

## Verification
Two things can land in the same cycle. The first is several start strobes arriving together while the block is idle. The second is a new strobe arriving on a cycle where a job is still shifting. The bench provokes the first with directed pairs and triples and with random mixes of all three strobes. It judges each case by decoding every chip-select frame off the pins and comparing the frames with the list that the priority rule predicts. For the second, it pulses every strobe in the middle of a user write. It then requires that exactly two frames appear, and that the bus stays quiet long after done.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;

  localparam int FRAME_BITS  = 24;
  localparam int ADDR_W      = 8;
  localparam int VALUE_W     = 16;
  localparam int JOB_SLOTS   = 2;
  localparam int SLOT_IDX_W  = (JOB_SLOTS > 1) ? $clog2(JOB_SLOTS) : 1;
  localparam int SLOT_CNT_W  = $clog2(JOB_SLOTS + 1);

  localparam logic [7:0]         SEL_PREFIX  = 8'h74;
  localparam logic [7:0]         VAL_PREFIX  = 8'h76;
  localparam logic [ADDR_W-1:0]  REG_POWER   = 8'h11;
  localparam logic [ADDR_W-1:0]  REG_DRIVE   = 8'h01;
  localparam logic [VALUE_W-1:0] POWER_WAKE  = 16'h0000;
  localparam logic [VALUE_W-1:0] POWER_SLEEP = 16'h0001;
  localparam logic [VALUE_W-1:0] DRIVE_BASE  = 16'h2AEF;
  // option bits: 8 scan L->R, 9 scan T->B, 11 BGR order, 13 normal display
  localparam logic [VALUE_W-1:0] DRIVE_OPTS  = 16'h2B00;

  typedef enum logic [1:0] {JOB_NONE, JOB_INIT, JOB_SHUT, JOB_USER} job_e;

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [VALUE_W-1:0] value;
  } reg_write_t;

  function automatic logic [VALUE_W-1:0] drive_word(input logic [VALUE_W-1:0] opts);
    return (DRIVE_BASE & ~DRIVE_OPTS) | (opts & DRIVE_OPTS);
  endfunction

  function automatic logic [FRAME_BITS-1:0] select_frame(input logic [ADDR_W-1:0] addr);
    return {SEL_PREFIX, 8'h00, addr};
  endfunction

  function automatic logic [FRAME_BITS-1:0] value_frame(input logic [VALUE_W-1:0] value);
    return {VAL_PREFIX, value};
  endfunction

  function automatic job_e pick_job(input logic want_init, input logic want_shut,
                                    input logic want_user);
    if (want_init)      return JOB_INIT;
    else if (want_shut) return JOB_SHUT;
    else if (want_user) return JOB_USER;
    else                return JOB_NONE;
  endfunction

endpackage

// File: rtl/panel_spi_shifter.sv
module panel_spi_shifter
  import panel_spi_pkg::*;
#(
  parameter int SCK_HALF = 2,
  parameter int BITS     = FRAME_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] word,
  output logic            sck,
  output logic            mosi,
  output logic            cs_n,
  output logic            frame_done
);
  localparam int GAP_LEN = 2 * SCK_HALF;
  localparam int CW      = $clog2(GAP_LEN + 1);
  localparam int BW      = $clog2(BITS);
  localparam logic [CW-1:0] HALF_END = CW'(SCK_HALF - 1);
  localparam logic [CW-1:0] GAP_END  = CW'(GAP_LEN - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

  typedef enum logic [2:0] {SH_IDLE, SH_LEAD, SH_LOW, SH_HIGH, SH_GAP} sh_state_e;

  sh_state_e       st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bit_no;
  logic [BITS-1:0] sh;
  logic            sck_q, cs_q, mosi_q, done_q;

  wire half_over = (cnt == HALF_END);
  wire gap_over  = (st == SH_GAP) && (cnt == GAP_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SH_IDLE; cnt <= '0; bit_no <= '0; sh <= '0;
      sck_q <= 1'b1; cs_q <= 1'b1; mosi_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= gap_over;
      unique case (st)
        SH_IDLE: if (start) begin
          sh <= word; mosi_q <= word[BITS-1]; cs_q <= 1'b0;
          cnt <= '0; st <= SH_LEAD;
        end
        SH_LEAD: if (half_over) begin
          sck_q <= 1'b0; cnt <= '0; bit_no <= '0; st <= SH_LOW;
        end else cnt <= cnt + 1'b1;
        SH_LOW: if (half_over) begin
          sck_q <= 1'b1; cnt <= '0; st <= SH_HIGH;
        end else cnt <= cnt + 1'b1;
        SH_HIGH: if (half_over) begin
          cnt <= '0;
          if (bit_no == LAST_BIT) begin
            cs_q <= 1'b1; mosi_q <= 1'b0; st <= SH_GAP;
          end else begin
            bit_no <= bit_no + 1'b1;
            sh     <= {sh[BITS-2:0], 1'b0};
            mosi_q <= sh[BITS-2];
            sck_q  <= 1'b0;
            st     <= SH_LOW;
          end
        end else cnt <= cnt + 1'b1;
        SH_GAP: if (gap_over) begin
          cnt <= '0; st <= SH_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign sck        = sck_q;
  assign mosi       = mosi_q;
  assign cs_n       = cs_q;
  assign frame_done = done_q;
endmodule

// File: rtl/panel_spi_jobsel.sv
module panel_spi_jobsel
  import panel_spi_pkg::*;
(
  input  logic                            busy,
  input  logic                            init_go,
  input  logic                            shut_go,
  input  logic                            wr_req,
  input  logic [VALUE_W-1:0]              mode_word,
  input  logic [ADDR_W-1:0]               wr_reg,
  input  logic [VALUE_W-1:0]              wr_data,
  output logic                            accept,
  output reg_write_t [JOB_SLOTS-1:0]      list,
  output logic [SLOT_CNT_W-1:0]           count
);
  job_e kind;

  always_comb begin
    kind   = pick_job(init_go, shut_go, wr_req);
    accept = !busy && (kind != JOB_NONE);
    list   = '0;
    count  = '0;
    unique case (kind)
      JOB_INIT: begin
        list[0] = '{addr: REG_POWER, value: POWER_WAKE};
        list[1] = '{addr: REG_DRIVE, value: drive_word(mode_word)};
        count   = SLOT_CNT_W'(2);
      end
      JOB_SHUT: begin
        list[0] = '{addr: REG_POWER, value: POWER_SLEEP};
        count   = SLOT_CNT_W'(1);
      end
      JOB_USER: begin
        list[0] = '{addr: wr_reg, value: wr_data};
        count   = SLOT_CNT_W'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/panel_spi_seq.sv
module panel_spi_seq
  import panel_spi_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accept,
  input  reg_write_t [JOB_SLOTS-1:0]  list,
  input  logic [SLOT_CNT_W-1:0]       count,
  input  logic                        frame_done,
  output logic                        frame_start,
  output logic [FRAME_BITS-1:0]       frame_word,
  output logic                        busy,
  output logic                        done
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_WAIT} sq_state_e;

  sq_state_e                  st;
  reg_write_t [JOB_SLOTS-1:0] held;
  logic [SLOT_CNT_W-1:0]      held_cnt;
  logic [SLOT_IDX_W-1:0]      slot;
  logic                       value_phase;
  logic                       done_q;

  wire last_slot = (SLOT_CNT_W'(slot) + SLOT_CNT_W'(1)) == held_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; held <= '0; held_cnt <= '0; slot <= '0;
      value_phase <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        SQ_IDLE: if (accept) begin
          held <= list; held_cnt <= count; slot <= '0;
          value_phase <= 1'b0; st <= SQ_LOAD;
        end
        SQ_LOAD: st <= SQ_WAIT;
        SQ_WAIT: if (frame_done) begin
          if (!value_phase) begin
            value_phase <= 1'b1; st <= SQ_LOAD;
          end else if (!last_slot) begin
            value_phase <= 1'b0; slot <= slot + 1'b1; st <= SQ_LOAD;
          end else begin
            st <= SQ_IDLE; done_q <= 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign frame_start = (st == SQ_LOAD);
  assign frame_word  = value_phase ? value_frame(held[slot].value)
                                   : select_frame(held[slot].addr);
  assign busy        = (st != SQ_IDLE);
  assign done        = done_q;
endmodule

// File: rtl/panel_spi_ctrl.sv
module panel_spi_ctrl
  import panel_spi_pkg::*;
#(
  parameter int SCK_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_go,
  input  logic        shut_go,
  input  logic [15:0] mode_word,
  input  logic        wr_req,
  input  logic [7:0]  wr_reg,
  input  logic [15:0] wr_data,
  output logic        sck,
  output logic        mosi,
  output logic        cs_n,
  output logic        busy,
  output logic        done
);
  logic                       accept;
  reg_write_t [JOB_SLOTS-1:0] list;
  logic [SLOT_CNT_W-1:0]      count;
  logic                       frame_start;
  logic                       frame_done;
  logic [FRAME_BITS-1:0]      frame_word;

  panel_spi_jobsel u_jobsel (
    .busy(busy), .init_go(init_go), .shut_go(shut_go), .wr_req(wr_req),
    .mode_word(mode_word), .wr_reg(wr_reg), .wr_data(wr_data),
    .accept(accept), .list(list), .count(count)
  );

  panel_spi_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .list(list), .count(count),
    .frame_done(frame_done), .frame_start(frame_start), .frame_word(frame_word),
    .busy(busy), .done(done)
  );

  panel_spi_shifter #(.SCK_HALF(SCK_HALF), .BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .word(frame_word),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .frame_done(frame_done)
  );
endmodule

// File: rtl/panel_spi_checks.sv
module panel_spi_checks (
  input logic clk,
  input logic rst_n,
  input logic init_go,
  input logic shut_go,
  input logic wr_req,
  input logic sck,
  input logic mosi,
  input logic cs_n,
  input logic busy,
  input logic done,
  input logic frame_start,
  input logic frame_done
);
  p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && sck));

  p_cs_fall_sck_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sck);

  p_cs_rise_sck_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> sck);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && $past(sck) && !$past(cs_n)) |-> $stable(mosi));

  p_start_on_idle_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> cs_n);

  p_end_on_idle_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> cs_n);

  p_busy_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((init_go || shut_go || wr_req) && !busy) |=> busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_end_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind panel_spi_ctrl panel_spi_checks u_chk (
  .clk(clk), .rst_n(rst_n), .init_go(init_go), .shut_go(shut_go),
  .wr_req(wr_req), .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy),
  .done(done), .frame_start(frame_start), .frame_done(frame_done)
);

// File: tb/sim_panel_spi_ctrl.sv
module sim_panel_spi_ctrl;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_go = 1'b0, shut_go = 1'b0, wr_req = 1'b0;
  logic [15:0] mode_word = '0, wr_data = '0;
  logic [7:0]  wr_reg = '0;
  wire sck, mosi, cs_n, busy, done;

  always #10 clk = ~clk;

  panel_spi_ctrl #(.SCK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .init_go(init_go), .shut_go(shut_go),
    .mode_word(mode_word), .wr_req(wr_req), .wr_reg(wr_reg), .wr_data(wr_data),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected-value helpers, restated from the requirements
  function automatic logic [23:0] want_sel(input logic [7:0] r);
    return 24'h740000 + {16'h0, r};
  endfunction
  function automatic logic [23:0] want_val(input logic [15:0] v);
    return 24'h760000 + {8'h0, v};
  endfunction
  function automatic logic [15:0] want_drive(input logic [15:0] m);
    logic [15:0] keep;
    keep = 16'h0100 | 16'h0200 | 16'h0800 | 16'h2000;
    return (m & keep) | 16'h00EF;
  endfunction

  // bus decoder at falling clock edges
  logic [23:0] cap [0:31];
  int cap_n = 0;
  logic p_sck = 1'b1, p_cs = 1'b1;
  logic [23:0] acc = '0;
  int nbits = 0, lowlen = 0, highlen = 0, gaplen = 0;
  bit seen_frame = 0;

  always @(negedge clk) if (rst_n) begin
    if (p_cs && !cs_n) begin
      chk(sck == 1'b1, "R2 sck at cs fall", sck, 1);
      if (seen_frame) chk(gaplen >= 2*HALF, "R5 cs gap", gaplen, 2*HALF);
      nbits = 0; acc = '0; lowlen = 0; highlen = 0;
    end
    if (!cs_n && !sck) lowlen++;
    if (!cs_n && sck && nbits > 0) highlen++;
    if (!cs_n && p_sck && !sck && nbits > 0) begin
      chk(highlen == HALF, "R12 high phase", highlen, HALF);
      highlen = 0;
    end
    if (!cs_n && !p_sck && sck) begin
      chk(lowlen == HALF, "R12 low phase", lowlen, HALF);
      lowlen = 0; highlen = 1;
      acc = {acc[22:0], mosi};
      nbits++;
    end
    if (!p_cs && cs_n) begin
      chk(sck == 1'b1, "R2 sck at cs rise", sck, 1);
      chk(nbits == 24, "R3 bits per frame", nbits, 24);
      if (cap_n < 32) cap[cap_n] = acc;
      cap_n++;
      seen_frame = 1;
      gaplen = 0;
    end
    if (cs_n) gaplen++;
    p_sck = sck; p_cs = cs_n;
  end

  // run one job; poke>0 pulses every strobe that many cycles in
  task automatic run_job(input bit gi, input bit gs, input bit gw,
                         input logic [15:0] m, input logic [7:0] r,
                         input logic [15:0] d, input int poke);
    logic [23:0] exp_f [0:3];
    int en;
    string tag;
    en = 0;
    if (gi) begin
      tag = (gs || gw) ? "R11 init wins" : "R6 init";
      exp_f[0] = want_sel(8'h11); exp_f[1] = want_val(16'h0000);
      exp_f[2] = want_sel(8'h01); exp_f[3] = want_val(want_drive(m));
      en = 4;
    end else if (gs) begin
      tag = gw ? "R11 shut wins" : "R7 shutdown";
      exp_f[0] = want_sel(8'h11); exp_f[1] = want_val(16'h0001); en = 2;
    end else begin
      tag = "R8 user write";
      exp_f[0] = want_sel(r); exp_f[1] = want_val(d); en = 2;
    end
    if (poke > 0) tag = "R10 ignored while busy";
    cap_n = 0;
    @(negedge clk);
    init_go = gi; shut_go = gs; wr_req = gw; mode_word = m; wr_reg = r; wr_data = d;
    @(negedge clk);
    init_go = 0; shut_go = 0; wr_req = 0;
    mode_word = 16'hFFFF; wr_reg = 8'hA5; wr_data = 16'h5A5A;
    chk(busy == 1'b1, "R9 busy after strobe", busy, 1);
    begin
      int t = 0;
      while (!done && t < 5000) begin
        if (poke > 0 && t == poke) begin
          init_go = 1; shut_go = 1; wr_req = 1;
          @(negedge clk); t++;
          init_go = 0; shut_go = 0; wr_req = 0;
        end else begin
          @(negedge clk); t++;
        end
        if (!done) chk(busy == 1'b1, "R9 busy held", busy, 1);
      end
    end
    chk(done == 1'b1, "R9 done pulse", done, 1);
    chk(busy == 1'b0, "R9 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    chk(cap_n == en, {tag, " frame count"}, cap_n, en);
    for (int k = 0; k < en && k < cap_n; k++) begin
      if (k % 2 == 0) chk(cap[k][23:8] == 16'h7400, "R3 index prefix", cap[k][23:8], 16'h7400);
      else            chk(cap[k][23:16] == 8'h76, "R4 data prefix", cap[k][23:16], 8'h76);
      chk(cap[k] == exp_f[k], tag, cap[k], exp_f[k]);
    end
    if (poke > 0) begin
      repeat (300) @(negedge clk);
      chk(cap_n == en, "R10 no late frame", cap_n, en);
      chk(cs_n && !busy, "R10 bus idle", {cs_n, busy}, 2'b10);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk(cs_n == 1 && sck == 1 && mosi == 0 && busy == 0 && done == 0,
        "R1 reset outputs", {cs_n, sck, mosi, busy, done}, 5'b11000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sck == 1 && busy == 0, "R1 idle after reset",
        {cs_n, sck, busy}, 3'b110);

    run_job(1, 0, 0, 16'h0000, 8'h00, 16'h0000, 0);   // R6 mode clear
    run_job(1, 0, 0, 16'hFFFF, 8'h00, 16'h0000, 0);   // R6 all bits set
    run_job(1, 0, 0, 16'h2A00, 8'h00, 16'h0000, 0);   // R6 normal, T->B, BGR
    run_job(0, 1, 0, 16'h0000, 8'h00, 16'h0000, 0);   // R7
    run_job(0, 0, 1, 16'h0000, 8'hFF, 16'hFFFF, 0);   // R8 all ones
    run_job(0, 0, 1, 16'h0000, 8'h00, 16'h8001, 0);   // R8 edge bits
    run_job(1, 1, 1, 16'h0100, 8'h12, 16'h3456, 0);   // R11 triple
    run_job(0, 1, 1, 16'h0000, 8'h12, 16'h3456, 0);   // R11 pair
    run_job(1, 0, 1, 16'h0800, 8'h33, 16'h4444, 0);   // R11 pair
    run_job(0, 0, 1, 16'h0000, 8'h5C, 16'hBEEF, 40);  // R10 poke mid-job
    run_job(1, 0, 0, 16'h2000, 8'h00, 16'h0000, 250); // R10 poke during init

    for (int n = 0; n < 24; n++) begin
      int combo;
      combo = $urandom_range(1, 7);
      run_job(combo[2], combo[1], combo[0], 16'($urandom()), 8'($urandom()),
              16'($urandom()), 0);
      repeat ($urandom_range(0, 6)) @(negedge clk);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule